// File: doc/BRIEF.md
# Token-Ring Depth-Cascaded FIFO

This block builds one deep first-in first-out buffer out of several identical small storage slices. Two tokens decide which slice is active. The write token marks the slice that accepts incoming words. The read token marks the slice whose words are returned. Each slice has one ring output, `xo`. It feeds the ring input of the next slice, and the last slice feeds the first, so the slices form a closed ring.

A slice sets its ring output high when it stores a word into its highest location. That rising level passes the write token to the next slice. A slice clears its ring output when it returns the word from its highest location. That falling level passes the read token to the next slice. Each slice samples its ring input on the common clock and takes a token when it sees the matching edge. The hand-over therefore costs one cycle, and during that cycle no slice holds the token.

The composite full and empty flags are formed from the states of all slices in parallel. The caller does not track which slice holds a token. At reset, a selector input picks the slice that starts with both tokens. Only the slice that holds the read token places its word on the merged output. The last word returned is held in a registered output.

Top module: `ring_cascade_fifo`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `empty` is 1, `full` is 0 and `rd_data` is 0.
- R2: Words are returned in the order they were accepted, across every slice boundary and across the wrap from the last slice back to the first.
- R3: Writing the highest location of the slice that holds the write token (location DEPTH-1) hands the write token to the next slice in ring order. The next slice after slice N_SLICES-1 is slice 0.
- R4: Reading the highest location of the slice that holds the read token hands the read token to the next slice in ring order.
- R5: A token hand-over leaves no holder of that token for exactly one cycle. During that cycle the matching composite flag (`full` for writes, `empty` for reads) is 1, and a request on that side is ignored.
- R6: `full` is 1 when the slice that holds the write token already stores DEPTH words. A write made while `full` is 1 changes neither the stored contents nor the order of the returned words.
- R7: `empty` is 1 when the slice that holds the read token stores no word. A read made while `empty` is 1 leaves `rd_data` unchanged.
- R8: A write and a read in the same cycle are both carried out when `full` and `empty` are both 0, whether they fall in the same slice or in different slices.
- R9: At any time at most one slice holds the write token and at most one slice holds the read token. `wr_tok` and `rd_tok` bit i is 1 while slice i holds that token.
- R10: At reset, the slice whose index equals `first_sel` takes both tokens. The other slices take none.
- R11: A single slice never stores more than DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous active-high reset |
| first_sel | input | $clog2(N_SLICES) | Index of the slice that starts with both tokens; sampled while `rst` is high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered last word returned |
| full | output | 1 | Composite full flag |
| empty | output | 1 | Composite empty flag |
| wr_tok | output | N_SLICES | One bit per slice, set while that slice holds the write token |
| rd_tok | output | N_SLICES | One bit per slice, set while that slice holds the read token |

## Verification
Three events can fall in the same cycle: a write that hands the write token on, a read in another slice, and sometimes a read that hands the read token on. The bench provokes this in two ways. It keeps the buffer partly filled and requests a read and a write on every cycle. It also fills one slice completely and then drains it while refilling the next slice. Each accepted word goes into a model queue in the bench, and each returned word is compared against the front of that queue. The token vectors are checked at the hand-over points to confirm that one slice releases a token while another slice keeps working.

// File: rtl/ring_pkg.sv
package ring_pkg;
  // Index width that never collapses to zero bits.
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ring_slice.sv
module ring_slice
  import ring_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lead_n,     // low: this slice starts with both tokens
  input  logic              xi,         // ring input from previous slice
  output logic              xo,         // ring output to next slice
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_word,   // zero unless this slice pops
  output logic              can_push,
  output logic              can_pop,
  output logic              has_wtok,
  output logic              has_rtok
);
  localparam int PW = idx_bits(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          xi_q;
  logic          wtok, rtok;

  wire w_in    = xi & ~xi_q;   // write token arrives
  wire r_in    = ~xi & xi_q;   // read token arrives
  wire do_push = push & can_push;
  wire do_pop  = pop & can_pop;

  assign can_push = wtok & (cnt != CAP);
  assign can_pop  = rtok & (cnt != '0);
  assign has_wtok = wtok;
  assign has_rtok = rtok;

  always_ff @(posedge clk) begin
    if (rst) begin
      wtok <= ~lead_n;
      rtok <= ~lead_n;
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      xo   <= 1'b0;
      xi_q <= 1'b0;
    end else begin
      xi_q <= xi;
      if (do_push) begin
        wp <= (wp == LAST) ? '0 : wp + 1'b1;
        if (wp == LAST) begin
          wtok <= 1'b0;
          xo   <= 1'b1;
        end
      end else if (w_in) begin
        wtok <= 1'b1;
      end
      if (do_pop) begin
        rp <= (rp == LAST) ? '0 : rp + 1'b1;
        if (rp == LAST) begin
          rtok <= 1'b0;
          xo   <= 1'b0;
        end
      end else if (r_in) begin
        rtok <= 1'b1;
      end
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  // Storage without reset so it can map onto block RAM.
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  assign pop_word = do_pop ? mem[rp] : '0;

  // R8: both hand-overs can never be requested by one slice in one cycle
  a_r8_no_dual_handoff: assert property (@(posedge clk) disable iff (rst)
    !(do_push && wp == LAST && do_pop && rp == LAST));

  // R11: occupancy never exceeds capacity
  a_r11_no_overfill: assert property (@(posedge clk) disable iff (rst)
    cnt <= CAP);

  // R3: after handing the write token on, the slice no longer holds it
  a_r3_release_wtok: assert property (@(posedge clk) disable iff (rst)
    $rose(xo) |-> !wtok);

  // R4: after handing the read token on, the slice no longer holds it
  a_r4_release_rtok: assert property (@(posedge clk) disable iff (rst)
    $fell(xo) |-> !rtok);
endmodule

// File: rtl/ring_cascade_fifo.sv
module ring_cascade_fifo
  import ring_pkg::*;
#(
  parameter int N_SLICES = 3,
  parameter int DEPTH    = 4,
  parameter int DATA_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [idx_bits(N_SLICES)-1:0] first_sel,
  input  logic                          wr_en,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          rd_en,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          full,
  output logic                          empty,
  output logic [N_SLICES-1:0]           wr_tok,
  output logic [N_SLICES-1:0]           rd_tok
);
  localparam int SW = idx_bits(N_SLICES);

  logic [N_SLICES-1:0] xo, can_push, can_pop;
  logic [DATA_W-1:0]   pop_word [N_SLICES];
  logic [DATA_W-1:0]   merged;

  for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
    localparam int PREV = (i + N_SLICES - 1) % N_SLICES;
    ring_slice #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_slice (
      .clk       (clk),
      .rst       (rst),
      .lead_n    (first_sel != SW'(i)),
      .xi        (xo[PREV]),
      .xo        (xo[i]),
      .push      (wr_en),
      .push_data (wr_data),
      .pop       (rd_en),
      .pop_word  (pop_word[i]),
      .can_push  (can_push[i]),
      .can_pop   (can_pop[i]),
      .has_wtok  (wr_tok[i]),
      .has_rtok  (rd_tok[i])
    );
  end

  // Flags from all slices in parallel.
  assign full  = ~|can_push;
  assign empty = ~|can_pop;

  always_comb begin
    merged = '0;
    for (int i = 0; i < N_SLICES; i++) merged = merged | pop_word[i];
  end

  always_ff @(posedge clk) begin
    if (rst)                  rd_data <= '0;
    else if (rd_en && !empty) rd_data <= merged;
  end

  // R9: token uniqueness
  a_r9_one_wtok: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_tok));
  a_r9_one_rtok: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_tok));

  // R5: a hand-over gap lasts exactly one cycle
  a_r5_wgap_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (wr_tok == '0) |=> ($countones(wr_tok) == 1));
  a_r5_rgap_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (rd_tok == '0) |=> ($countones(rd_tok) == 1));

  // R7: a read while empty keeps the output word
  a_r7_hold_when_empty: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> $stable(rd_data));
endmodule

// File: tb/test_ring_cascade_fifo.sv
module test_ring_cascade_fifo;
  localparam int N = 3;
  localparam int D = 4;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   first_sel = '0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rd_en = 1'b0;
  logic [W-1:0] rd_data;
  logic         full, empty;
  logic [N-1:0] wr_tok, rd_tok;

  int checks = 0;
  int fails  = 0;
  int q[$];
  logic [W-1:0] next_val = 8'h10;

  always #2 clk = ~clk;  // 250 MHz

  ring_cascade_fifo #(.N_SLICES(N), .DEPTH(D), .DATA_W(W)) i_ring_cascade_fifo (
    .clk(clk), .rst(rst), .first_sel(first_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .full(full), .empty(empty), .wr_tok(wr_tok), .rd_tok(rd_tok)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One cycle: inputs driven at the falling edge, results seen at the next one.
  task automatic step(input logic we, input logic re, input string req);
    logic acc_w, acc_r;
    acc_w = we && !full;
    acc_r = re && !empty;
    wr_en = we;
    rd_en = re;
    wr_data = next_val;
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
    if (acc_w) begin
      q.push_back(int'(next_val));
      next_val = next_val + 1'b1;
    end
    if (acc_r) chk(req, rd_data, q.pop_front());
  endtask

  task automatic do_reset(input logic [1:0] sel);
    first_sel = sel;
    rst = 1'b1;
    q.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    rst = 1'b1;
    first_sel = 2'd0;
    @(negedge clk);
    chk("R1 empty in reset", empty, 1);
    chk("R1 full in reset", full, 0);
    do_reset(2'd1);
    chk("R1 empty after reset", empty, 1);
    chk("R1 full after reset", full, 0);
    chk("R1 rd_data after reset", rd_data, 0);
    chk("R10 wr_tok at slice 1", wr_tok, 3'b010);
    chk("R10 rd_tok at slice 1", rd_tok, 3'b010);
  endtask

  task automatic t_fill_and_drain;
    logic [W-1:0] held;
    do_reset(2'd0);
    for (int i = 0; i < D; i++) step(1'b1, 1'b0, "R2");
    chk("R5 no write holder in gap", wr_tok, 3'b000);
    chk("R5 full in gap", full, 1);
    step(1'b1, 1'b0, "R5");            // ignored during the gap
    chk("R3 write token to slice 1", wr_tok, 3'b010);
    chk("R5 gap write dropped", q.size(), D);
    chk("R5 full cleared", full, 0);
    for (int k = 0; k < 40 && q.size() < N*D; k++) step(1'b1, 1'b0, "R2");
    chk("R6 all slices filled", q.size(), N*D);
    step(1'b0, 1'b0, "R6");
    step(1'b0, 1'b0, "R6");
    chk("R3 write token wraps to slice 0", wr_tok, 3'b001);
    chk("R6 full with slice 0 occupied", full, 1);
    step(1'b1, 1'b0, "R6");            // must be ignored
    chk("R6 write while full dropped", q.size(), N*D);
    for (int i = 0; i < D; i++) step(1'b0, 1'b1, "R2 order");
    chk("R4 no read holder in gap", rd_tok, 3'b000);
    chk("R5 empty in read gap", empty, 1);
    held = rd_data;
    step(1'b0, 1'b1, "R5");
    chk("R7 rd_data held in gap", rd_data, held);
    chk("R4 read token to slice 1", rd_tok, 3'b010);
    for (int k = 0; k < 40 && q.size() > 0; k++) step(1'b0, 1'b1, "R2 order");
    chk("R2 all words returned", q.size(), 0);
    step(1'b0, 1'b0, "R7");
    chk("R7 empty after drain", empty, 1);
    held = rd_data;
    step(1'b0, 1'b1, "R7");
    chk("R7 read while empty holds data", rd_data, held);
    chk("R4 read token wraps to slice 0", rd_tok, 3'b001);
  endtask

  task automatic t_concurrent;
    do_reset(2'd0);
    step(1'b1, 1'b0, "R8");
    step(1'b1, 1'b0, "R8");
    for (int k = 0; k < 30; k++) step(1'b1, 1'b1, "R8 concurrent order");
    for (int k = 0; k < 40 && q.size() > 0; k++) step(1'b0, 1'b1, "R8 drain");
    chk("R8 drained", q.size(), 0);
    // Fill slice 0, then drain it while filling slice 1.
    do_reset(2'd0);
    for (int i = 0; i < D; i++) step(1'b1, 1'b0, "R8");
    step(1'b0, 1'b0, "R8");
    for (int k = 0; k < D + 2; k++) step(1'b1, 1'b1, "R8 cross-slice order");
    chk("R8 write token in slice 2", wr_tok, 3'b100);
    for (int k = 0; k < 40 && q.size() > 0; k++) step(1'b0, 1'b1, "R8 drain");
    chk("R8 drained cross-slice", q.size(), 0);
  endtask

  task automatic t_first_sel;
    do_reset(2'd2);
    chk("R10 tokens at slice 2", wr_tok, 3'b100);
    for (int k = 0; k < 10 && q.size() < D + 1; k++) step(1'b1, 1'b0, "R10");
    chk("R3 ring wraps 2 to 0", wr_tok, 3'b001);
    for (int k = 0; k < 20 && q.size() > 0; k++) step(1'b0, 1'b1, "R10 order");
    chk("R10 read token wrapped", rd_tok, 3'b001);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_fill_and_drain();
    t_concurrent();
    t_first_sel();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule